// File: doc/BRIEF.md
# Line-Frequency Tick Clock

This block is a real-time tick peripheral for a 16-bit peripheral bus. It turns a periodic tick into a ready flag and an interrupt request. The tick comes either from an external one-cycle pulse or from an internal divider on the reference clock. The divider runs at either 60 or 50 ticks per second, and a reset selects 60. Software sees one control/status word. In that word, bit 6 is the interrupt enable and bit 7 is the ready (monitor) flag.

Three strap inputs select the variant. `strapNoReg` removes the register. The block then forces interrupts on and reports a bus error for every access. `strapMonitor` makes bit 7 readable and lets software clear it. `strapAckClr` makes an interrupt acknowledge clear ready as well as the request. `strapNoReg` is captured while reset is held. `strapMonitor` and `strapAckClr` act combinationally.

Top module: `ltc_top`

## Requirements
- R1: While reset is low and at the first cycle after it, ready is 1, enable is 0 and `irq` is 0. `rdData` reads 0x0080 with `strapMonitor`=1 and 0x0000 with `strapMonitor`=0.
- R2: An even write to the present register (`addrOdd`=0) loads enable from `wrData[6]`. All read bits other than 7 and 6 are always 0.
- R3: A tick sets ready one cycle later. If enable or force-enable is then 1, the tick also sets the request, and `irq` is 1 one cycle later.
- R4: With `strapMonitor`=0, `rdData[7]` reads 0, and a write with bit 7 = 0 leaves ready unchanged.
- R5: With `strapMonitor`=1, an even write with `wrData[7]`=0 clears ready, and a write with `wrData[7]`=1 leaves ready as it was.
- R6: A write never raises the request. After an even write, the request is 0 if the resulting enable and force are both 0, or if the resulting ready is 0.
- R7: A write with `addrOdd`=1 changes neither enable nor ready nor the request.
- R8: If `strapNoReg`=1 during reset, then any access (`regSel`=1) drives `busErr`=1, `rdData` reads 0, writes have no effect, and every tick raises `irq` regardless of enable.
- R9: With `tickSel`=1, ticks come every REF_HZ/60 reference cycles after reset. After a `rateLoad` pulse with `rateSel50`=1, they come every REF_HZ/50 cycles. A reset restores REF_HZ/60.
- R10: An `intAck` pulse clears the request. With `strapAckClr`=1 it also clears ready.
- R11: In a cycle where a tick coincides with a write or an acknowledge, the write and the acknowledge apply first and the tick applies last. Ready ends at 1, and the request ends at 1 if the post-write enable or force is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Synchronous active-low reset |
| strapNoReg | input | 1 | Register absent variant (captured in reset) |
| strapMonitor | input | 1 | Ready bit readable and clearable |
| strapAckClr | input | 1 | Acknowledge also clears ready |
| tickSel | input | 1 | 1: internal divider, 0: external tick |
| extTick | input | 1 | External one-cycle tick pulse |
| rateLoad | input | 1 | Load the tick rate selection |
| rateSel50 | input | 1 | Rate to load: 1 = 50/s, 0 = 60/s |
| regSel | input | 1 | Register access this cycle |
| regWr | input | 1 | Access is a write |
| addrOdd | input | 1 | Odd-byte access |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data |
| busErr | output | 1 | Non-existent register access |
| irq | output | 1 | Interrupt request |
| intAck | input | 1 | Interrupt acknowledge pulse |

## Verification
A tick can land in the same cycle as a register write or an interrupt acknowledge. The bench provokes this with directed tick-plus-write and tick-plus-acknowledge cycles. It also lets the random stream of writes, ticks and acknowledges overlap freely. Each cycle, a bench model that applies the write, then the acknowledge, then the tick predicts `rdData` and `irq` for comparison.

// File: rtl/ltc_pkg.sv
package ltc_pkg;
  localparam int DATA_W    = 16;
  localparam int READY_BIT = 7;
  localparam int IE_BIT    = 6;

  typedef struct packed {
    logic tick;      // one tick this cycle
    logic wrEven;    // accepted even-byte write
    logic ack;       // interrupt acknowledge
    logic rateLoad;  // load rate selection
    logic rate50;    // selection value
  } ctrlStrb_t;
endpackage

// File: rtl/ltc_divider.sv
module ltc_divider #(
  parameter int REF_HZ  = 3000,
  parameter int RATE_HI = 60,
  parameter int RATE_LO = 50
) (
  input  logic clk,
  input  logic rstN,
  input  logic rateLoad,
  input  logic rate50,
  output logic divTick
);
  localparam int TERM_HI = REF_HZ / RATE_HI;
  localparam int TERM_LO = REF_HZ / RATE_LO;
  localparam int TERM_MAX = (TERM_LO > TERM_HI) ? TERM_LO : TERM_HI;
  localparam int CNT_W = $clog2(TERM_MAX + 1);

  logic             useLo;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastCnt;

  assign lastCnt = useLo ? CNT_W'(TERM_LO - 1) : CNT_W'(TERM_HI - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      useLo   <= 1'b0;
      cnt     <= '0;
      divTick <= 1'b0;
    end else begin
      if (rateLoad) useLo <= rate50;
      if (cnt >= lastCnt) begin
        cnt     <= '0;
        divTick <= 1'b1;
      end else begin
        cnt     <= cnt + 1'b1;
        divTick <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ltc_ctrl.sv
module ltc_ctrl
  import ltc_pkg::*;
(
  input  logic      tickSel,
  input  logic      extTick,
  input  logic      divTick,
  input  logic      rateLoad,
  input  logic      rateSel50,
  input  logic      regSel,
  input  logic      regWr,
  input  logic      addrOdd,
  input  logic      intAck,
  input  logic      nxm,
  output ctrlStrb_t strb,
  output logic      busErr
);
  always_comb begin
    strb.tick     = tickSel ? divTick : extTick;
    strb.wrEven   = regSel & regWr & ~addrOdd & ~nxm;
    strb.ack      = intAck;
    strb.rateLoad = rateLoad;
    strb.rate50   = rateSel50;
  end

  assign busErr = regSel & nxm;
endmodule

// File: rtl/ltc_datapath.sv
module ltc_datapath
  import ltc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapNoReg,
  input  logic              strapMonitor,
  input  logic              strapAckClr,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              nxm,
  output logic              forceEn,
  output logic              readyQ,
  output logic              ieQ
);
  logic reqQ;
  logic rdyN, ieN, reqN;

  // Order inside a cycle: write, then acknowledge, then tick
  always_comb begin
    rdyN = readyQ;
    ieN  = ieQ;
    reqN = reqQ;
    if (strb.wrEven) begin
      ieN = wrData[IE_BIT];
      if (strapMonitor && !wrData[READY_BIT]) rdyN = 1'b0;
      if ((!ieN && !forceEn) || !rdyN) reqN = 1'b0;
    end
    if (strb.ack) begin
      reqN = 1'b0;
      if (strapAckClr) rdyN = 1'b0;
    end
    if (strb.tick) begin
      rdyN = 1'b1;
      if (ieN || forceEn) reqN = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ  <= 1'b1;
      ieQ     <= 1'b0;
      reqQ    <= 1'b0;
      forceEn <= strapNoReg;
      nxm     <= strapNoReg;
    end else begin
      readyQ <= rdyN;
      ieQ    <= ieN;
      reqQ   <= reqN;
    end
  end

  always_comb begin
    rdData = '0;
    if (!nxm) begin
      rdData[READY_BIT] = readyQ & strapMonitor;
      rdData[IE_BIT]    = ieQ;
    end
  end

  assign irq = reqQ;
endmodule

// File: rtl/ltc_top.sv
module ltc_top
  import ltc_pkg::*;
#(
  parameter int REF_HZ  = 3000,
  parameter int RATE_HI = 60,
  parameter int RATE_LO = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapNoReg,
  input  logic              strapMonitor,
  input  logic              strapAckClr,
  input  logic              tickSel,
  input  logic              extTick,
  input  logic              rateLoad,
  input  logic              rateSel50,
  input  logic              regSel,
  input  logic              regWr,
  input  logic              addrOdd,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              busErr,
  output logic              irq,
  input  logic              intAck
);
  ctrlStrb_t strb;
  logic divTick, nxm, forceEn, readyQ, ieQ;

  ltc_divider #(.REF_HZ(REF_HZ), .RATE_HI(RATE_HI), .RATE_LO(RATE_LO)) uDiv (
    .clk(clk), .rstN(rstN), .rateLoad(strb.rateLoad), .rate50(strb.rate50),
    .divTick(divTick)
  );

  ltc_ctrl uCtrl (
    .tickSel(tickSel), .extTick(extTick), .divTick(divTick),
    .rateLoad(rateLoad), .rateSel50(rateSel50), .regSel(regSel),
    .regWr(regWr), .addrOdd(addrOdd), .intAck(intAck), .nxm(nxm),
    .strb(strb), .busErr(busErr)
  );

  ltc_datapath uDp (
    .clk(clk), .rstN(rstN), .strapNoReg(strapNoReg),
    .strapMonitor(strapMonitor), .strapAckClr(strapAckClr), .strb(strb),
    .wrData(wrData), .rdData(rdData), .irq(irq), .nxm(nxm),
    .forceEn(forceEn), .readyQ(readyQ), .ieQ(ieQ)
  );
endmodule

// File: rtl/ltc_checker.sv
module ltc_checker (
  input logic        clk,
  input logic        rstN,
  input logic        tick,
  input logic        wrEven,
  input logic        ack,
  input logic        forceEn,
  input logic        ready,
  input logic        ie,
  input logic        irq,
  input logic        regSel,
  input logic        regWr,
  input logic        addrOdd,
  input logic [15:0] wrData
);
  assert_tick_ready_R3: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> ready);

  assert_force_irq_R8: assert property (@(posedge clk) disable iff (!rstN)
    (tick && forceEn) |=> irq);

  assert_ack_drop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !tick) |=> !irq);

  assert_write_noraise_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEven && !tick && !irq) |=> !irq);

  assert_odd_ignore_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && regWr && addrOdd && !tick && !ack) |=> ($stable(ie) && $stable(ready)));

  assert_ie_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrEven |=> (ie == $past(wrData[6])));
endmodule

bind ltc_top ltc_checker uChk (
  .clk(clk), .rstN(rstN), .tick(strb.tick), .wrEven(strb.wrEven),
  .ack(strb.ack), .forceEn(forceEn), .ready(readyQ), .ie(ieQ), .irq(irq),
  .regSel(regSel), .regWr(regWr), .addrOdd(addrOdd), .wrData(wrData)
);

// File: tb/sim_ltc_top.sv
`timescale 1ns/1ps
module sim_ltc_top;
  localparam int REF_HZ = 3000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strapNoReg = 1'b0, strapMonitor = 1'b1, strapAckClr = 1'b0;
  logic tickSel = 1'b0, extTick = 1'b0, rateLoad = 1'b0, rateSel50 = 1'b0;
  logic regSel = 1'b0, regWr = 1'b0, addrOdd = 1'b0, intAck = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic busErr, irq;

  int nChecks = 0, nFails = 0, cyc = 0;
  bit done = 0;
  // bench model
  bit mRdy, mIe, mReq, mForce;

  ltc_top #(.REF_HZ(REF_HZ)) u0 (.*);

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expRd();
    logic [15:0] v = '0;
    if (!mForce) begin
      v[7] = mRdy & strapMonitor;
      v[6] = mIe;
    end
    return v;
  endfunction

  task automatic doReset(bit noReg, bit mon, bit ackc);
    @(negedge clk);
    strapNoReg = noReg; strapMonitor = mon; strapAckClr = ackc;
    rstN = 1'b0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    mRdy = 1; mIe = 0; mReq = 0; mForce = noReg;
  endtask

  // One cycle of stimulus; model applies write, then ack, then tick
  task automatic step(string req, bit wr, bit odd, logic [15:0] d, bit tk, bit ak);
    regSel = wr; regWr = wr; addrOdd = odd; wrData = d; extTick = tk; intAck = ak;
    @(negedge clk);
    regSel = 0; regWr = 0; addrOdd = 0; extTick = 0; intAck = 0;
    if (wr && !odd && !mForce) begin
      mIe = d[6];
      if (strapMonitor && !d[7]) mRdy = 0;
      if ((!mIe && !mForce) || !mRdy) mReq = 0;
    end
    if (ak) begin
      mReq = 0;
      if (strapAckClr) mRdy = 0;
    end
    if (tk) begin
      mRdy = 1;
      if (mIe || mForce) mReq = 1;
    end
    chk({req, " rdData"}, rdData, expRd());
    chk({req, " irq"}, {15'd0, irq}, {15'd0, mReq});
  endtask

  task automatic measure(output int per);
    int times[3];
    int ev = 0;
    for (int i = 0; i < 600 && ev < 3; i++) begin
      @(negedge clk);
      intAck = 0;
      if (irq) begin
        times[ev] = cyc;
        ev++;
        intAck = 1;
      end
    end
    intAck = 0;
    per = (ev == 3) ? times[2] - times[1] : -1;
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int per;
    void'($urandom(32'h5eed));

    // R1 reset state
    doReset(0, 1, 0);
    chk("R1 reset read mon", rdData, 16'h0080);
    chk("R1 reset irq", {15'd0, irq}, 16'h0);
    doReset(0, 0, 0);
    chk("R1 reset read nomon", rdData, 16'h0000);

    // R2 / R5 / R3 / R6
    doReset(0, 1, 0);
    step("R2 write all ones", 1, 0, 16'hFFFF, 0, 0);
    chk("R2 only bits 7,6", rdData, 16'h00C0);
    step("R5 write bit7=0 clears ready", 1, 0, 16'h0000, 0, 0);
    chk("R5 ready cleared", rdData, 16'h0000);
    step("R3 tick sets ready, ie off", 0, 0, 0, 1, 0);
    chk("R3 ready no irq", {rdData[7], irq}, 16'h2);
    step("R6 write ie no raise", 1, 0, 16'h00C0, 0, 0);
    chk("R6 no irq after write", {15'd0, irq}, 16'h0);
    step("R3 tick raises irq", 0, 0, 0, 1, 0);
    chk("R3 irq set", {15'd0, irq}, 16'h1);
    step("R6 write keeps irq", 1, 0, 16'h00C0, 0, 0);
    step("R6 write clear drops", 1, 0, 16'h0000, 0, 0);
    chk("R6 irq dropped", {15'd0, irq}, 16'h0);

    // R7 odd write ignored
    step("R7 odd write", 1, 1, 16'h00C0, 0, 0);
    chk("R7 read unchanged", rdData, 16'h0000);

    // R10 acknowledge
    step("R10 set ie", 1, 0, 16'h00C0, 0, 0);
    step("R10 tick", 0, 0, 0, 1, 0);
    step("R10 ack", 0, 0, 0, 0, 1);
    chk("R10 ready kept", rdData, 16'h00C0);
    doReset(0, 1, 1);
    step("R10 set ie ackclr", 1, 0, 16'h00C0, 0, 0);
    step("R10 tick ackclr", 0, 0, 0, 1, 0);
    step("R10 ack clears ready", 0, 0, 0, 0, 1);
    chk("R10 ready cleared", rdData, 16'h0040);

    // R11 coincidences
    doReset(0, 1, 0);
    step("R11 tick+write clear", 1, 0, 16'h0000, 1, 0);
    chk("R11 ready wins", rdData, 16'h0080);
    step("R11 tick+write ie", 1, 0, 16'h0040, 1, 0);
    chk("R11 irq from tick", {15'd0, irq}, 16'h1);
    step("R11 tick+ack", 0, 0, 0, 1, 1);
    chk("R11 irq survives ack", {15'd0, irq}, 16'h1);

    // R4 no monitor bit
    doReset(0, 0, 0);
    step("R4 write bit7=0", 1, 0, 16'h0040, 0, 0);
    chk("R4 ready hidden", rdData, 16'h0040);
    strapMonitor = 1; #1;
    chk("R4 ready survived", rdData, 16'h00C0);
    @(negedge clk); strapMonitor = 0;

    // R8 register absent
    doReset(1, 1, 0);
    regSel = 1; #1;
    chk("R8 busErr", {15'd0, busErr}, 16'h1);
    chk("R8 read zero", rdData, 16'h0000);
    regSel = 0; #1;
    chk("R8 no busErr idle", {15'd0, busErr}, 16'h0);
    step("R8 write ignored", 1, 0, 16'h0000, 0, 0);
    step("R8 forced irq", 0, 0, 0, 1, 0);
    chk("R8 irq forced", {15'd0, irq}, 16'h1);

    // R9 divider
    doReset(0, 1, 0);
    tickSel = 1;
    step("R9 enable", 1, 0, 16'h00C0, 0, 0);
    measure(per);
    chk("R9 period 60", per[15:0], 16'(REF_HZ / 60));
    @(negedge clk); rateLoad = 1; rateSel50 = 1;
    @(negedge clk); rateLoad = 0; rateSel50 = 0;
    measure(per);
    chk("R9 period 50", per[15:0], 16'(REF_HZ / 50));
    doReset(0, 1, 0);
    step("R9 enable again", 1, 0, 16'h00C0, 0, 0);
    measure(per);
    chk("R9 reset restores 60", per[15:0], 16'(REF_HZ / 60));
    tickSel = 0;

    // Random mix, R11 coincidences included
    for (int seg = 0; seg < 6; seg++) begin
      doReset(seg == 5, $urandom_range(0, 1), $urandom_range(0, 1));
      for (int n = 0; n < 300; n++) begin
        logic [15:0] d = 16'($urandom);
        step("R11 random", $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
             d, $urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule